// File: doc/BRIEF.md
# Filtered Tamper Input Detector

The block watches a set of asynchronous tamper pins, two by default, and keeps a sticky flag for each pin. A flag is set when a valid event arrives on an enabled pin. Each pin passes through a two-flop synchronizer first. The detection method depends on the shared filter setting. With the filter off, the block detects a single edge on the synchronized pin. With the filter on, it checks the pin level on a slow sampling strobe and declares an event only after a run of consecutive samples at the active level.

The sampling strobe comes from a free-running divider on the block clock. A 3-bit code sets the divide ratio, from 32768 (code 0) down to 256 (code 7). Just before each sample, the block drives a pull-up request for a programmed number of clocks so that an external pad can be precharged.

Software clears a flag by writing a one to its clear bit. A shared interrupt enable gates the interrupt output, which is high while any flag is set. A separate enable turns each accepted event into a one-cycle pulse that a timestamp unit can use to capture the time.

Top module: `tamper_detect`

## Requirements
- R1: While reset is asserted, and afterwards until the first event, `flag_o`, `irq_o`, `stamp_o` and `pullup_o` are all 0. Reset asserts at once and releases after two clock edges.
- R2: With `filt_sel_i` = 0 and `act_sel_i[i]` = 0, a rising edge on `tamp_i[i]` sets `flag_o[i]`. The flag becomes visible after the third rising clock edge following the pin change.
- R3: With `filt_sel_i` = 0 and `act_sel_i[i]` = 1, only a falling edge sets the flag. A rising edge has no effect.
- R4: A pin whose `chan_en_i[i]` is 0 never sets its flag, whatever the pin does, and its sample run count is held at zero.
- R5: With `filt_sel_i` = f (1, 2 or 3), a sample is taken once every 2^(15-`rate_sel_i`) clocks. The flag is set on the 2^f-th consecutive sample at the active level: high when `act_sel_i[i]` = 1, low when it is 0. The run then starts again from zero.
- R6: A sample that is not at the active level resets the run count to zero, so shorter runs never set the flag.
- R7: When `stamp_en_i` = 1, `stamp_o` pulses high for exactly one cycle, the same cycle in which an accepted event sets a flag. When `stamp_en_i` = 0, `stamp_o` stays low.
- R8: `irq_o` is high exactly when `irq_en_i` is 1 and at least one flag is set.
- R9: A set flag stays set until a clock edge at which the matching bit of `flag_clr_i` is 1. At that edge the flag clears.
- R10: If an event and a clear for the same flag fall on the same clock edge, the flag is set.
- R11: When the filter is on and at least one pin is enabled, `pullup_o` is high for exactly 2^`chg_sel_i` clocks immediately before each sample cycle. At other times, and always when the filter is off, it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the clock that the sample divider counts |
| rst_n | input | 1 | Asynchronous active-low reset |
| tamp_i | input | NCH | Asynchronous tamper pins |
| chan_en_i | input | NCH | Per-pin detection enable |
| act_sel_i | input | NCH | Edge mode: 0 rising, 1 falling. Level mode: 0 low active, 1 high active |
| filt_sel_i | input | 2 | 0 edge mode; 1, 2 or 3 require 2, 4 or 8 consecutive samples |
| rate_sel_i | input | 3 | Sample period of 2^(15-code) clocks |
| chg_sel_i | input | 2 | Precharge length of 2^code clocks before each sample |
| irq_en_i | input | 1 | Shared interrupt enable |
| stamp_en_i | input | 1 | Emit a timestamp pulse on accepted events |
| flag_clr_i | input | NCH | Write-one-to-clear strobes for the flags |
| flag_o | output | NCH | Sticky tamper flags |
| irq_o | output | 1 | Interrupt request |
| stamp_o | output | 1 | One-cycle timestamp capture pulse |
| pullup_o | output | 1 | Pull-up request during the precharge window |

## Verification
The hardest case to reach is a run that falls one sample short of the count. The bench cannot see the divider phase, so it holds the pin active for a span too short to contain four samples at any phase, then drops it for a span long enough to contain at least one sample. It repeats this pattern before holding the pin long enough to succeed. The case of an event arriving together with a clear is reached by holding the clear bit high through the whole edge sequence. A behavioural model then predicts every output on every cycle, including the exact precharge windows across changes of rate and precharge code.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int unsigned RATE_W   = 3;
  localparam int unsigned FILT_W   = 2;
  localparam int unsigned CHG_W    = 2;
  localparam int unsigned SLOW_LOG = 8;

  typedef enum logic [FILT_W-1:0] {
    FLT_EDGE = 2'd0,
    FLT_RUN2 = 2'd1,
    FLT_RUN4 = 2'd2,
    FLT_RUN8 = 2'd3
  } filt_mode_e;
endpackage

// File: rtl/tamper_rst_sync.sv
module tamper_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/tamper_sync.sv
module tamper_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] st_q;
  logic [STAGES-1:0][WIDTH-1:0] st_d;

  always_comb begin
    st_d = {st_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/tamper_pacer.sv
module tamper_pacer
  import tamper_pkg::*;
#(
  parameter int unsigned RATE_BITS = RATE_W,
  parameter int unsigned SLOW      = SLOW_LOG,
  parameter int unsigned CHG_BITS  = CHG_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RATE_BITS-1:0] rate_i,
  input  logic [CHG_BITS-1:0]  chg_i,
  output logic                 strobe_o,
  output logic                 charge_o
);
  localparam int unsigned CNT_W = SLOW + (1 << RATE_BITS) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] span, phase, chg_len, chg_start;

  always_comb begin
    span      = {CNT_W{1'b1}} >> rate_i;
    phase     = cnt_q & span;
    chg_len   = CNT_W'(1) << chg_i;
    chg_start = span - chg_len;
    strobe_o  = (phase == span);
    charge_o  = (phase >= chg_start) && (phase != span);
    cnt_d     = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tamper_channel.sv
module tamper_channel
  import tamper_pkg::*;
#(
  parameter int unsigned FILT_BITS = FILT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 level_i,
  input  logic                 en_i,
  input  logic                 sel_i,
  input  logic [FILT_BITS-1:0] filt_i,
  input  logic                 strobe_i,
  input  logic                 clr_i,
  output logic                 hit_o,
  output logic                 flag_o
);
  localparam int unsigned MAX_NEED = 1 << ((1 << FILT_BITS) - 1);
  localparam int unsigned RUN_W    = $clog2(MAX_NEED) + 1;

  logic             prev_q, prev_d;
  logic [RUN_W-1:0] run_q, run_d, run_inc, need;
  logic             flag_q, flag_d;
  logic             edge_hit, lvl_match, edge_mode, hit;

  always_comb begin
    edge_mode = (filt_i == '0);
    edge_hit  = sel_i ? (prev_q & ~level_i) : (~prev_q & level_i);
    lvl_match = (level_i == sel_i);
    need      = RUN_W'(1) << filt_i;
    run_inc   = run_q + RUN_W'(1);
    prev_d    = level_i;
    run_d     = run_q;
    hit       = 1'b0;
    if (!en_i || edge_mode) begin
      run_d = '0;
      hit   = en_i && edge_mode && edge_hit;
    end else if (strobe_i) begin
      if (!lvl_match) begin
        run_d = '0;
      end else if (run_inc >= need) begin
        run_d = '0;
        hit   = 1'b1;
      end else begin
        run_d = run_inc;
      end
    end
    flag_d = hit | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign hit_o  = hit;
  assign flag_o = flag_q;
endmodule

// File: rtl/tamper_detect.sv
module tamper_detect
  import tamper_pkg::*;
#(
  parameter int unsigned NCH         = 2,
  parameter int unsigned RATE_BITS   = RATE_W,
  parameter int unsigned FILT_BITS   = FILT_W,
  parameter int unsigned CHG_BITS    = CHG_W,
  parameter int unsigned SLOW        = SLOW_LOG,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       tamp_i,
  input  logic [NCH-1:0]       chan_en_i,
  input  logic [NCH-1:0]       act_sel_i,
  input  logic [FILT_BITS-1:0] filt_sel_i,
  input  logic [RATE_BITS-1:0] rate_sel_i,
  input  logic [CHG_BITS-1:0]  chg_sel_i,
  input  logic                 irq_en_i,
  input  logic                 stamp_en_i,
  input  logic [NCH-1:0]       flag_clr_i,
  output logic [NCH-1:0]       flag_o,
  output logic                 irq_o,
  output logic                 stamp_o,
  output logic                 pullup_o
);
  logic           sys_rst_n;
  logic [NCH-1:0] pin_s;
  logic [NCH-1:0] hit_w;
  logic [NCH-1:0] flag_w;
  logic           strobe;
  logic           charge;
  logic           stamp_q, stamp_d;

  tamper_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_ni (rst_n),
    .rst_no  (sys_rst_n)
  );

  tamper_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .d_i   (tamp_i),
    .q_o   (pin_s)
  );

  tamper_pacer #(.RATE_BITS(RATE_BITS), .SLOW(SLOW), .CHG_BITS(CHG_BITS)) u_pacer (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .rate_i   (rate_sel_i),
    .chg_i    (chg_sel_i),
    .strobe_o (strobe),
    .charge_o (charge)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    tamper_channel #(.FILT_BITS(FILT_BITS)) u_chan (
      .clk      (clk),
      .rst_n    (sys_rst_n),
      .level_i  (pin_s[g]),
      .en_i     (chan_en_i[g]),
      .sel_i    (act_sel_i[g]),
      .filt_i   (filt_sel_i),
      .strobe_i (strobe),
      .clr_i    (flag_clr_i[g]),
      .hit_o    (hit_w[g]),
      .flag_o   (flag_w[g])
    );
  end

  always_comb begin
    stamp_d = stamp_en_i & (|hit_w);
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) stamp_q <= 1'b0;
    else            stamp_q <= stamp_d;
  end

  assign flag_o   = flag_w;
  assign stamp_o  = stamp_q;
  assign irq_o    = irq_en_i & (|flag_w);
  assign pullup_o = charge & (filt_sel_i != '0) & (|chan_en_i);
endmodule

// File: rtl/tamper_detect_chk.sv
module tamper_detect_chk #(
  parameter int unsigned NCH       = 2,
  parameter int unsigned FILT_BITS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH-1:0]       chan_en_i,
  input logic [FILT_BITS-1:0] filt_sel_i,
  input logic [NCH-1:0]       flag_clr_i,
  input logic                 stamp_en_i,
  input logic [NCH-1:0]       flag_o,
  input logic                 irq_o,
  input logic                 stamp_o,
  input logic                 pullup_o,
  input logic                 strobe
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[g] && !flag_clr_i[g]) |=> flag_o[g]); // R9
    AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o[g]) |-> $past(chan_en_i[g])); // R4
    AST_LEVEL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag_o[g]) && ($past(filt_sel_i) != '0)) |-> $past(strobe)); // R5
  end

  AST_STAMP_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_o |-> ($past(stamp_en_i) && (|flag_o))); // R7
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|flag_o)); // R8
  AST_PULL_FILTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_o |-> ((filt_sel_i != '0) && !strobe)); // R11
endmodule

bind tamper_detect tamper_detect_chk #(.NCH(NCH), .FILT_BITS(FILT_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (sys_rst_n),
  .chan_en_i  (chan_en_i),
  .filt_sel_i (filt_sel_i),
  .flag_clr_i (flag_clr_i),
  .stamp_en_i (stamp_en_i),
  .flag_o     (flag_o),
  .irq_o      (irq_o),
  .stamp_o    (stamp_o),
  .pullup_o   (pullup_o),
  .strobe     (strobe)
);

// File: tb/tamper_detect_test.sv
`timescale 1ns/1ps
module tamper_detect_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] tamp, en, sel, clr, filt, chg;
  logic [2:0] rate;
  logic       irq_en, stamp_en;
  logic [1:0] flag_o;
  logic       irq_o, stamp_o, pullup_o;

  tamper_detect uut (
    .clk(clk), .rst_n(rst_n), .tamp_i(tamp), .chan_en_i(en), .act_sel_i(sel),
    .filt_sel_i(filt), .rate_sel_i(rate), .chg_sel_i(chg), .irq_en_i(irq_en),
    .stamp_en_i(stamp_en), .flag_clr_i(clr), .flag_o(flag_o), .irq_o(irq_o),
    .stamp_o(stamp_o), .pullup_o(pullup_o)
  );

  int total = 0;
  int bad = 0;
  int stamp_seen = 0;
  int pull_seen = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference model
  bit       m_rs1 = 0, m_rs2 = 0;
  bit [1:0] m_s1 = 0, m_s = 0, m_prev = 0, m_flag = 0;
  bit       m_stamp = 0;
  int       m_run[2] = '{0, 0};
  int       m_cnt = 0;

  always @(posedge clk) begin : model
    int p;
    bit strobe;
    bit [1:0] ev;
    if (!rst_n || !m_rs2) begin
      m_s1 = 0; m_s = 0; m_prev = 0; m_flag = 0; m_stamp = 0;
      m_run[0] = 0; m_run[1] = 0; m_cnt = 0;
    end else begin
      p = 1 << (15 - int'(rate));
      strobe = ((m_cnt % p) == p - 1);
      ev = 0;
      for (int i = 0; i < 2; i++) begin
        if (en[i] && filt == 0)
          ev[i] = sel[i] ? (m_prev[i] & ~m_s[i]) : (~m_prev[i] & m_s[i]);
        else if (en[i] && strobe) begin
          if (m_s[i] == sel[i]) begin
            if (m_run[i] + 1 >= (1 << int'(filt))) begin
              ev[i] = 1; m_run[i] = 0;
            end else m_run[i] = m_run[i] + 1;
          end else m_run[i] = 0;
        end
        if (!en[i] || filt == 0) m_run[i] = 0;
      end
      m_flag = ev | (m_flag & ~clr);
      m_stamp = stamp_en & (|ev);
      m_prev = m_s; m_s = m_s1; m_s1 = tamp;
      m_cnt = (m_cnt + 1) % 32768;
    end
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0;
    end else begin
      m_rs2 = m_rs1; m_rs1 = 1;
    end
  end

  function automatic bit model_pull();
    int p, low, pc;
    p = 1 << (15 - int'(rate));
    low = m_cnt % p;
    pc = 1 << int'(chg);
    return (filt != 0) && (|en) && (low >= p - 1 - pc) && (low <= p - 2);
  endfunction

  always begin
    @(negedge clk);
    #1;
    if (mon_on) begin
      check("R9 flag per cycle", flag_o, m_flag);
      check("R8 irq per cycle", irq_o, irq_en & (|m_flag));
      check("R7 stamp per cycle", stamp_o, m_stamp);
      check("R11 pullup per cycle", pullup_o, model_pull());
      if (stamp_o) stamp_seen++;
      if (pullup_o) pull_seen++;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tamp = 0; en = 0; sel = 0; clr = 0; filt = 0; chg = 0; rate = 3'd7;
    irq_en = 0; stamp_en = 0;
    mon_on = 1;
    tick(3);
    check("R1 flag in reset", flag_o, 0);
    check("R1 irq in reset", irq_o, 0);
    check("R1 stamp in reset", stamp_o, 0);
    check("R1 pullup in reset", pullup_o, 0);
    rst_n = 1;
    tick(4);
    check("R1 flag after release", flag_o, 0);

    en = 2'b11; irq_en = 1; stamp_en = 1;
    // R2 rising edge on pin 0
    tamp[0] = 1;
    tick(3);
    check("R2 rising edge flag", flag_o[0], 1);
    tick(2);
    check("R7 one stamp pulse", stamp_seen, 1);
    check("R8 irq with flag", irq_o, 1);
    irq_en = 0; tick(1);
    check("R8 irq gated", irq_o, 0);
    irq_en = 1;
    // R9 clear
    clr = 2'b01; tick(1); clr = 0; tick(1);
    check("R9 flag cleared", flag_o[0], 0);
    // R10 event with clear held
    tamp[0] = 0; tick(4);
    check("R2 falling ignored", flag_o[0], 0);
    clr = 2'b01; tamp[0] = 1;
    tick(3);
    check("R10 event beats clear", flag_o[0], 1);
    tick(1);
    check("R9 clear after event", flag_o[0], 0);
    clr = 0;
    // R3 falling edge on pin 1
    sel[1] = 1; tamp[1] = 1; tick(5);
    check("R3 rising ignored", flag_o[1], 0);
    tamp[1] = 0; tick(3);
    check("R3 falling edge flag", flag_o[1], 1);
    clr = 2'b10; tick(1); clr = 0; tick(1);
    // R4 disabled pin
    en[1] = 0; tamp[1] = 1; tick(5); tamp[1] = 0; tick(5);
    check("R4 disabled pin", flag_o[1], 0);
    // R11 no pullup in edge mode
    pull_seen = 0; tick(600);
    check("R11 no pullup edge mode", pull_seen, 0);
    // R5 high level, two samples, pin 0 held high
    filt = 2'd1; sel[0] = 1;
    tick(2 * 256 + 20);
    check("R5 level run of two", flag_o[0], 1);
    // R11 precharge window length
    chg = 2'd2; tick(1);
    pull_seen = 0; tick(1024);
    check("R11 precharge cycles", pull_seen, 16);
    // R6 interrupted runs, four samples
    filt = 2'd2; tamp[0] = 0; tick(10);
    clr = 2'b01; tick(1); clr = 0;
    for (int k = 0; k < 3; k++) begin
      tamp[0] = 1; tick(700);
      tamp[0] = 0; tick(300);
    end
    check("R6 short runs rejected", flag_o[0], 0);
    tamp[0] = 1; tick(1300);
    check("R6 full run accepted", flag_o[0], 1);
    // R5 low level on pin 1, slower rate
    filt = 2'd1; rate = 3'd6; sel[1] = 0; tamp[1] = 0; en[1] = 1;
    tick(3 * 512);
    check("R5 low level slow rate", flag_o[1], 1);
    tick(10);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule